// File: doc/BRIEF.md
# I2C Bus Monitor Byte Capture

This block listens passively to an I2C bus. Both bus lines are brought into the system clock domain through a two-flop synchroniser. The block then detects START, repeated START and STOP conditions, and on every rising SCL edge inside a transfer it shifts the SDA level into a nine-bit live shift register. When the ninth bit of a frame arrives, the frame is complete: eight data bits and then the acknowledge bit.

At the end of each frame the data byte and its acknowledge bit are copied into a holding buffer. A one-cycle capture pulse is raised, and a sticky interrupt flag is set. The shift register keeps moving as the next frame arrives, but the buffer keeps its value for the whole of that next frame. Software therefore has nine bit times to fetch the byte, instead of the single bit time that reading the shift register would allow.

Both registers can be read at any time through one read port. The block never drives the bus; its clock-hold output is held inactive.

Top module: `i2c_snoop_capture`

## Requirements
- R1: After reset the holding buffer, its acknowledge bit, the live shift register, the interrupt flag and the capture pulse are all zero.
- R2: On the ninth rising SCL edge after a START, the buffer loads the first eight sampled bits, MSB first, as the byte and the ninth as the acknowledge bit. With rd_sel=1, rd_data[8:1] is the byte and rd_data[0] is the acknowledge bit.
- R3: Between two frame completions the buffer does not change, including across the first eight bits of the following frame.
- R4: With rd_sel=0, rd_data holds the last nine sampled SDA bits, with the newest bit in rd_data[0]. This port is readable at any time.
- R5: cap_pulse is high for exactly one clock per completed frame.
- R6: irq is set by a capture and stays set until irq_clr is high. When a capture and irq_clr fall in the same cycle, irq stays set.
- R7: A START or a repeated START resets the bit count to zero, so that a partly received frame is discarded.
- R8: After a STOP, SCL edges shift no bits and cause no capture until the next START.
- R9: scl_hold_low is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| rd_sel | input | 1 | Read select: 0 selects the live shift register, 1 selects the buffer |
| irq_clr | input | 1 | Clears the interrupt flag |
| rd_data | output | 9 | Read data: the selected register |
| cap_pulse | output | 1 | One-cycle pulse on each buffer load |
| irq | output | 1 | Sticky capture interrupt flag |
| scl_hold_low | output | 1 | Clock-hold request, always inactive |

## Verification
A buffer load and a software clear of the interrupt flag can land on the same clock edge. The bench provokes this by watching for the capture pulse while a frame is being sent and raising irq_clr in that same cycle. It then requires irq to remain set, and a lone clear afterwards must drop it. A second overlap arises when the buffer stays fixed while the live register advances: every byte value is swept, and the buffer is compared against the previous byte after each early bit of the next frame.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  // Bits per frame for a given data width (data bits plus acknowledge).
  function automatic int unsigned frame_bits(int unsigned data_w);
    return data_w + 1;
  endfunction

  // Next bit position within a frame; wraps after the last bit.
  function automatic int unsigned next_pos(int unsigned pos, int unsigned data_w);
    return (pos >= data_w) ? 0 : pos + 1;
  endfunction
endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '1;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/snoop_line_events.sv
module snoop_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/snoop_frame_shifter.sv
module snoop_frame_shifter
  import snoop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_s,
  output logic [DATA_W:0] shreg,
  output logic          frame_done,
  output logic          active
);
  localparam int FB    = frame_bits(DATA_W);
  localparam int CNT_W = $clog2(FB);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [CNT_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      pos        <= '0;
      active     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (start_evt) begin
        active <= 1'b1;
        pos    <= '0;
      end else if (stop_evt) begin
        active <= 1'b0;
      end else if (active && scl_rise) begin
        shreg <= {shreg[DATA_W-1:0], sda_s};
        pos   <= CNT_W'(next_pos(int'(pos), DATA_W));
        if (pos == LAST) frame_done <= 1'b1;
      end
    end
  end

  // R7: a START always restarts the frame
  assert_start_resets_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (pos == '0));

  // R8: no shifting while the bus is idle
  assert_idle_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_evt) |=> ($stable(shreg) && !frame_done));
endmodule

// File: rtl/snoop_hold_buffer.sv
module snoop_hold_buffer #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DATA_W:0] din,
  input  logic            irq_clr,
  output logic [DATA_W:0] hold,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      irq  <= 1'b0;
    end else begin
      if (load) hold <= din;
      if (load) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R2: the buffer takes the frame that just completed
  assert_load_takes_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hold == $past(din)));

  // R3: the buffer holds between loads
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold));

  // R6: a capture always leaves the flag set
  assert_irq_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> irq);
endmodule

// File: rtl/i2c_snoop_capture.sv
module i2c_snoop_capture #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          rd_sel,
  input  logic          irq_clr,
  output logic [DATA_W:0] rd_data,
  output logic          cap_pulse,
  output logic          irq,
  output logic          scl_hold_low
);
  logic [1:0] line_s;
  logic scl_rise, start_evt, stop_evt, frame_done, active;
  logic [DATA_W:0] shreg, hold;

  snoop_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );

  snoop_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  snoop_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .start_evt(start_evt),
    .stop_evt(stop_evt), .sda_s(line_s[0]), .shreg(shreg),
    .frame_done(frame_done), .active(active)
  );

  snoop_hold_buffer #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .din(shreg),
    .irq_clr(irq_clr), .hold(hold), .irq(irq)
  );

  assign rd_data      = rd_sel ? hold : shreg;
  assign cap_pulse    = frame_done;
  assign scl_hold_low = 1'b0;

  // R5: the capture pulse lasts a single clock
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
endmodule

// File: tb/i2c_snoop_capture_bench.sv
module i2c_snoop_capture_bench;
  localparam int Q = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, rd_sel = 1'b0, irq_clr = 1'b0;
  logic [8:0] rd_data;
  logic cap_pulse, irq, scl_hold_low;
  int errors = 0, checks = 0, caps = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_snoop_capture u_i2c_snoop_capture (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .rd_sel(rd_sel),
    .irq_clr(irq_clr), .rd_data(rd_data), .cap_pulse(cap_pulse), .irq(irq),
    .scl_hold_low(scl_hold_low)
  );

  always @(negedge clk) begin
    if (cap_pulse) caps++;
    if (rst_n && scl_hold_low !== 1'b0) begin
      errors++;
      $display("FAIL R9 scl_hold_low actual=%b expected=0", scl_hold_low);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_reg(input logic sel, output logic [8:0] v);
    @(negedge clk);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sda = b; wait_q(Q);
    scl = 1'b1; wait_q(2*Q);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic send_start();
    @(negedge clk); sda = 1'b1; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    sda = 1'b0; wait_q(2*Q);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic send_stop();
    @(negedge clk); sda = 1'b0; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    sda = 1'b1; wait_q(2*Q);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] v, prev, idle_live;
    int c0;
    wait_q(3);
    // R1: reset state
    read_reg(1'b0, v); check("R1 live", v, 0);
    read_reg(1'b1, v); check("R1 buffer", v, 0);
    check("R1 irq", irq, 0);
    check("R1 cap", cap_pulse, 0);
    rst_n = 1'b1;
    wait_q(4);

    // Sweep all byte values in one transfer; R2 R3 R4 R5
    send_start();
    prev = 9'h0;
    for (int b = 0; b < 256; b++) begin
      logic [8:0] fr;
      fr = {b[7:0], b[0] ^ b[3]};
      c0 = caps;
      for (int i = 8; i >= 0; i--) begin
        send_bit(fr[i]);
        if (i > 0) begin
          read_reg(1'b1, v); check("R3 buffer held", v, prev);
        end
      end
      read_reg(1'b1, v); check("R2 buffer byte+ack", v, fr);
      read_reg(1'b0, v); check("R4 live shift", v, fr);
      check("R5 one pulse per frame", caps - c0, 1);
      prev = fr;
    end
    check("R6 irq set", irq, 1);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R6 irq cleared", irq, 0);

    // R7: repeated START discards partial frame
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    c0 = caps;
    send_start();
    send_frame(8'h5A, 1'b1);
    read_reg(1'b1, v); check("R7 buffer after restart", v, {8'h5A, 1'b1});
    check("R7 single capture", caps - c0, 1);

    // R6: clear and capture in the same cycle
    fork
      send_frame(8'hC3, 1'b0);
      begin
        @(negedge clk);
        while (!cap_pulse) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
      end
    join
    check("R6 set beats clear", irq, 1);
    read_reg(1'b1, v); check("R6 collision buffer", v, {8'hC3, 1'b0});
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R6 clear alone", irq, 0);

    // R8: idle bus ignores SCL edges
    send_stop();
    read_reg(1'b0, idle_live);
    c0 = caps;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); scl = 1'b0; wait_q(Q);
      scl = 1'b1; wait_q(Q);
    end
    wait_q(Q);
    read_reg(1'b0, v); check("R8 live unchanged when idle", v, idle_live);
    read_reg(1'b1, v); check("R8 buffer unchanged when idle", v, {8'hC3, 1'b0});
    check("R8 no capture when idle", caps - c0, 0);
    check("R8 irq stays clear", irq, 0);
    checks++; // R9 monitored every cycle
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule